// File: doc/BRIEF.md
# Modem Line Status Tracker

This block watches the four incoming modem handshake lines of a serial port (clear-to-send, data-set-ready, ring indicate and carrier detect). It brings each one into the local clock domain through a chain of synchronising flip-flops. For each line it keeps a sticky change flag, and it raises a modem-status interrupt condition whenever a flag is set and the interrupt is enabled. Software reads one 8-bit status word. The word holds the change flags in its lower half and the present line levels in its upper half. The read clears the change flags, so each read reports only what happened since the previous read.

A loopback mode is provided for self-test. While it is enabled, the four lines are taken from the port's own modem-control outputs rather than from the pins. Those outputs are request-to-send, data-terminal-ready and the two general-purpose outputs. Address decoding and the ranking of this interrupt against other interrupt sources are handled outside the block.

Top module: `modem_status_unit`

## Requirements
- R1: `status_q` bits 4, 5, 6 and 7 report the synchronised levels of CTS, DSR, RI and DCD respectively (1 = line high).
- R2: A cycle with `status_rd` high captures the status word into `status_q` at that clock edge. `status_q` then holds until the next read. Bits 0, 1, 2 and 3 are the change flags for CTS, DSR, RI and DCD.
- R3: The CTS, DSR and DCD change flags (bits 0, 1, 3) are set by any level change of their line, rising or falling.
- R4: The RI change flag (bit 2) is set only when ring indicate goes from 1 to 0. A rising RI sets no flag.
- R5: A change flag, once set, stays set through any number of cycles without a read.
- R6: A read clears bits 0 to 3 after their value has been captured. A change detected in the same cycle as the read stays set and is reported by the following read.
- R7: `msi_irq` is a register equal to `msi_enable` AND (any change flag set). With `msi_enable` low it stays 0.
- R8: With `loopback_en` high, the pins are ignored: CTS follows `rts_ctl`, DSR follows `dtr_ctl`, RI follows `out1_ctl` and DCD follows `out2_ctl`.
- R9: After reset, with all line inputs low, the change flags, `status_q` and `msi_irq` are all 0.
- R10: An input change set up before clock edge k shows as a level in a read that captures at edge k+2. Its change flag first appears in a read that captures at edge k+3 (two synchroniser stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_pin | input | 1 | Clear-to-send line from the pin |
| dsr_pin | input | 1 | Data-set-ready line from the pin |
| ri_pin | input | 1 | Ring indicate line from the pin |
| dcd_pin | input | 1 | Carrier detect line from the pin |
| rts_ctl | input | 1 | Request-to-send control output, looped to CTS |
| dtr_ctl | input | 1 | Data-terminal-ready control output, looped to DSR |
| out1_ctl | input | 1 | General output 1, looped to RI |
| out2_ctl | input | 1 | General output 2, looped to DCD |
| loopback_en | input | 1 | Take the lines from the control outputs instead of the pins |
| msi_enable | input | 1 | Modem-status interrupt enable |
| status_rd | input | 1 | One-cycle read strobe for the status word |
| status_q | output | 8 | Captured status word: flags [3:0], levels [7:4] |
| msi_irq | output | 1 | Modem-status interrupt condition |

## Verification
Single-line toggles on each line separate the any-edge lines from ring indicate. A rising RI must leave bit 2 clear, while a falling RI must set it. Random multi-line patterns with reads at random points are checked against a bench model of levels and sticky flags. These show that flags accumulate between reads and that the read clears them. Loopback patterns drive pins and control outputs to opposite values, so a wrong source or a swapped mapping shows in the upper nibble. A directed case lands a CTS change exactly on the read cycle. It tells apart a design that drops that change from one that keeps it for the next read, and it pins the two-stage latency of level and flag.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int MSD_LINES = 4;
  localparam int STAT_W    = 2 * MSD_LINES;
  // line index order inside every vector of this block
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  localparam logic [MSD_LINES-1:0] TRAIL_ONLY = 4'b0100; // RI flagged on 1->0 only
  typedef logic [MSD_LINES-1:0] line_vec_t;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/msd_delta.sv
module msd_delta #(
  parameter int               WIDTH      = 4,
  parameter logic [WIDTH-1:0] TRAIL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  input  logic             clr,
  output logic [WIDTH-1:0] lvl_prev,
  output logic [WIDTH-1:0] evt,
  output logic [WIDTH-1:0] flags,
  output logic [WIDTH-1:0] flags_nxt
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    if (TRAIL_MASK[i]) begin : g_trail
      assign evt[i] = lvl_prev[i] & ~lvl[i];
    end else begin : g_any
      assign evt[i] = lvl_prev[i] ^ lvl[i];
    end
  end

  // a fresh event wins over the clear of the same cycle
  assign flags_nxt = (flags & ~{WIDTH{clr}}) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= '0;
      flags    <= '0;
    end else begin
      lvl_prev <= lvl;
      flags    <= flags_nxt;
    end
  end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cts_pin,
  input  logic              dsr_pin,
  input  logic              ri_pin,
  input  logic              dcd_pin,
  input  logic              rts_ctl,
  input  logic              dtr_ctl,
  input  logic              out1_ctl,
  input  logic              out2_ctl,
  input  logic              loopback_en,
  input  logic              msi_enable,
  input  logic              status_rd,
  output logic [STAT_W-1:0] status_q,
  output logic              msi_irq
);
  line_vec_t pin_vec, loop_vec, src_vec;
  line_vec_t lvl, lvl_prev, evt, flags, flags_nxt;

  assign pin_vec  = {dcd_pin, ri_pin, dsr_pin, cts_pin};
  assign loop_vec = {out2_ctl, out1_ctl, dtr_ctl, rts_ctl};
  assign src_vec  = loopback_en ? loop_vec : pin_vec;

  msd_sync #(
    .WIDTH (MSD_LINES),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (src_vec),
    .q  (lvl)
  );

  msd_delta #(
    .WIDTH     (MSD_LINES),
    .TRAIL_MASK(TRAIL_ONLY)
  ) u_delta (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .clr      (status_rd),
    .lvl_prev (lvl_prev),
    .evt      (evt),
    .flags    (flags),
    .flags_nxt(flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      msi_irq  <= 1'b0;
    end else begin
      if (status_rd) status_q <= {lvl, flags};
      msi_irq <= msi_enable & (|flags_nxt);
    end
  end
endmodule

// File: rtl/msd_checker.sv
module msd_checker
  import msd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              status_rd,
  input logic              msi_enable,
  input logic              msi_irq,
  input logic [STAT_W-1:0] status_q,
  input line_vec_t         lvl,
  input line_vec_t         lvl_prev,
  input line_vec_t         flags
);
  a_r2_read_captures: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> (status_q == $past({lvl, flags})));

  a_r4_ri_trailing_only: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[IDX_RI]) |-> ($past(lvl_prev[IDX_RI]) && !$past(lvl[IDX_RI])));

  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !status_rd |=> ((flags & $past(flags)) == $past(flags)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (status_rd && (lvl == lvl_prev)) |=> (flags == '0));

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !msi_enable |=> !msi_irq);

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    msi_irq |-> (|flags));
endmodule

bind modem_status_unit msd_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .status_rd (status_rd),
  .msi_enable(msi_enable),
  .msi_irq   (msi_irq),
  .status_q  (status_q),
  .lvl       (lvl),
  .lvl_prev  (lvl_prev),
  .flags     (flags)
);

// File: tb/sim_modem_status_unit.sv
module sim_modem_status_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cts_pin = 0, dsr_pin = 0, ri_pin = 0, dcd_pin = 0;
  logic       rts_ctl = 0, dtr_ctl = 0, out1_ctl = 0, out2_ctl = 0;
  logic       loopback_en = 0, msi_enable = 0, status_rd = 0;
  logic [7:0] status_q;
  logic       msi_irq;

  int checks = 0;
  int fails  = 0;

  // bench model, line order CTS, DSR, RI, DCD
  logic [3:0] m_lvl   = '0;
  logic [3:0] m_flags = '0;
  logic       m_en    = 1'b0;

  always #2.5 clk = ~clk; // 200 MHz

  modem_status_unit u0 (
    .clk(clk), .rst(rst),
    .cts_pin(cts_pin), .dsr_pin(dsr_pin), .ri_pin(ri_pin), .dcd_pin(dcd_pin),
    .rts_ctl(rts_ctl), .dtr_ctl(dtr_ctl), .out1_ctl(out1_ctl), .out2_ctl(out2_ctl),
    .loopback_en(loopback_en), .msi_enable(msi_enable), .status_rd(status_rd),
    .status_q(status_q), .msi_irq(msi_irq)
  );

  function automatic logic [3:0] next_flags(logic [3:0] old_l, logic [3:0] new_l,
                                            logic [3:0] fl);
    logic [3:0] r = fl;
    for (int i = 0; i < 4; i++) begin
      if (i == 2) r[i] = r[i] | (old_l[i] & ~new_l[i]);
      else        r[i] = r[i] | (old_l[i] ^ new_l[i]);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pins and ctl given in line order; ctl[0]=rts, [1]=dtr, [2]=out1, [3]=out2
  task automatic apply(logic [3:0] pins, logic [3:0] ctl, logic lb, logic en);
    logic [3:0] src;
    @(negedge clk);
    {dcd_pin, ri_pin, dsr_pin, cts_pin} = pins;
    {out2_ctl, out1_ctl, dtr_ctl, rts_ctl} = ctl;
    loopback_en = lb;
    msi_enable  = en;
    repeat (4) @(posedge clk);
    @(negedge clk);
    src     = lb ? ctl : pins; // R8 source selection
    m_flags = next_flags(m_lvl, src, m_flags);
    m_lvl   = src;
    m_en    = en;
    check("R7 irq", {7'd0, msi_irq}, {7'd0, m_en & (|m_flags)});
  endtask

  task automatic do_read(string tag);
    @(negedge clk);
    status_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    status_rd = 1'b0;
    check(tag, status_q, {m_lvl, m_flags});
    m_flags = '0;
    check("R6 irq after read", {7'd0, msi_irq}, 8'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 status", status_q, 8'h00);
    check("R9 irq", {7'd0, msi_irq}, 8'd0);
    do_read("R9 first read");

    // R3 CTS rise and DCD rise, R1 levels
    apply(4'b0001, 4'b0000, 0, 1);
    do_read("R3 cts rise / R1");
    apply(4'b1001, 4'b0000, 0, 1);
    do_read("R3 dcd rise");
    apply(4'b1000, 4'b0000, 0, 1);
    do_read("R3 cts fall");

    // R4 RI rising gives no flag, falling does
    apply(4'b1100, 4'b0000, 0, 1);
    do_read("R4 ri rise no flag");
    apply(4'b1000, 4'b0000, 0, 1);
    do_read("R4 ri fall flag");

    // R5 sticky across several steps
    apply(4'b1010, 4'b0000, 0, 1);
    apply(4'b1010, 4'b0000, 0, 1);
    repeat (20) @(posedge clk);
    apply(4'b0010, 4'b0000, 0, 1);
    do_read("R5 sticky dsr+dcd");

    // R7 enable low: flags set, irq held low
    apply(4'b0011, 4'b0000, 0, 0);
    do_read("R7 disabled");

    // R8 loopback with pins opposite to ctl
    apply(4'b1111, 4'b0000, 1, 1);
    do_read("R8 loop all low");
    apply(4'b0000, 4'b1011, 1, 1);
    do_read("R8 loop mapping");
    apply(4'b0000, 4'b0000, 0, 1);
    do_read("R8 back to pins");

    // R6 / R10: CTS change lands on the read cycle
    apply(4'b0010, 4'b0000, 0, 1);
    @(negedge clk);
    cts_pin = 1'b1;            // setup before edge k
    @(posedge clk);            // k
    @(posedge clk);            // k+1
    @(negedge clk);
    status_rd = 1'b1;
    @(posedge clk);            // k+2 capture
    @(negedge clk);
    status_rd = 1'b0;
    check("R10 level at k+2, R6 old flags", status_q, {4'b0011, m_flags});
    m_lvl   = 4'b0011;
    m_flags = 4'b0001;
    check("R6 kept change raises irq", {7'd0, msi_irq}, 8'd1);
    do_read("R6 same-cycle change kept");

    // random patterns
    for (int n = 0; n < 80; n++) begin
      logic [3:0] p, c;
      logic lb, en;
      p  = 4'($urandom);
      c  = 4'($urandom);
      lb = ($urandom % 4) == 0;
      en = ($urandom % 3) != 0;
      apply(p, c, lb, en);
      if (($urandom % 3) == 0) do_read("R1 R3 R4 R5 random");
    end
    do_read("R5 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule